// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This unit fixes up an 8-bit accumulator byte after an ordinary binary add or subtract has been applied to BCD operands. It handles two BCD layouts. In the packed layout one byte carries two decimal digits. In the unpacked layout the low byte carries one digit and a companion high byte collects the decimal carry or borrow. The caller presents an operation code, the low byte, the high byte and the incoming auxiliary-carry (AF) and carry (CF) flags, together with a one-cycle request strobe. One clock later the unit returns the corrected bytes, the new AF and CF and, if enabled, a zero flag.

A small control block turns the operation code and the incoming flags into a set of correction strobes. A datapath block applies those strobes and registers the results. The adder that produced the raw sum and the register file that holds the accumulator sit outside the unit.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While `rstN` is low, every result output and `outValid` read 0, whatever the other inputs do.
- R2: The low-digit correction fires when the low nibble of `inAl` is greater than 9 or when `inAf` is 1. The returned `outAf` is 1 exactly when it fires, for every operation.
- R3: With `opSel` = 2'b00 (packed, after add), the unit adds 06h when R2 fires. It also adds 60h and returns CF = 1 when the original `inAl` exceeds 99h or `inCf` is 1, and otherwise returns CF = 0. For example, 0Fh becomes 15h.
- R4: With `opSel` = 2'b01 (packed, after subtract), the unit subtracts 06h and 60h under the same two conditions as R3, with the same flag results. For example, FFh becomes 99h with CF = 1.
- R5: With `opSel` = 2'b10 (unpacked, after add), when R2 fires the unit adds 6 to AL, adds 1 to AH modulo 256 and returns AF = CF = 1. Otherwise AH is unchanged and AF = CF = 0. The high nibble of the returned AL is always 0. For example, AH:AL = 00:0F becomes 01:05.
- R6: With `opSel` = 2'b11 (unpacked, after subtract), when R2 fires the unit subtracts 6 from AL, subtracts 1 from AH modulo 256 and returns AF = CF = 1. Otherwise AH is unchanged and AF = CF = 0, even if `inCf` was 1. The high nibble of the returned AL is always 0. For example, 02:FF becomes 01:09.
- R7: Both packed operations return `outAh` equal to `inAh`.
- R8: `outZf` is 1 exactly when the returned `outAl` is 00h.
- R9: Results and `outValid` = 1 appear on the first rising edge after the edge that samples `inValid` = 1. A cycle with `inValid` = 0 returns `outValid` = 0 on the next edge and leaves every result output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe: sample the operands this cycle |
| opSel | input | 2 | Adjust operation: 00 packed add, 01 packed sub, 10 unpacked add, 11 unpacked sub |
| inAl | input | 8 | Low accumulator byte after the binary operation |
| inAh | input | 8 | High accumulator byte (used by the unpacked operations) |
| inAf | input | 1 | Incoming auxiliary-carry flag |
| inCf | input | 1 | Incoming carry flag |
| outAl | output | 8 | Corrected low byte |
| outAh | output | 8 | Corrected high byte |
| outAf | output | 1 | Updated auxiliary-carry flag |
| outCf | output | 1 | Updated carry flag |
| outZf | output | 1 | Zero flag of `outAl` (0 when ZF_EN = 0) |
| outValid | output | 1 | Results were loaded on this edge |

## Verification
The bench builds the unit with its default parameters: 4-bit digits, which gives 8-bit bytes, and the zero flag enabled. These defaults make the decimal thresholds 9 and 99h and the step values 06h and 60h, so the vector table can drive each of the four operations through its corner cases. Those cases include:
- the low-digit correction fired by the AF input alone;
- the high correction fired by the CF input alone;
- AL values that sit exactly on the 9 and 99h thresholds;
- AH wrapping in both directions;
- AL wrapping to zero, which also sets the zero flag.

With the zero flag enabled, the same vectors also check ZF for every result.

// File: rtl/bcdadj_pkg.sv
package bcdadj_pkg;

  typedef enum logic [1:0] {
    OP_PACK_ADD = 2'b00,
    OP_PACK_SUB = 2'b01,
    OP_UNP_ADD  = 2'b10,
    OP_UNP_SUB  = 2'b11
  } adjOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic subtract;  // apply corrections downward
    logic unpacked;  // one digit per byte, carry into high byte
    logic lowFix;    // low-digit correction fires
    logic highFix;   // high-digit correction fires (packed only)
  } adjStrobe_t;

endpackage

// File: rtl/bcdadj_ctrl.sv
module bcdadj_ctrl
  import bcdadj_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic                   inValid,
  input  logic [1:0]             opSel,
  input  logic [2*DIGIT_W-1:0]   inAl,
  input  logic                   inAf,
  input  logic                   inCf,
  output adjStrobe_t             stb
);

  localparam int BYTE_W = 2 * DIGIT_W;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = DIGIT_W'(9);
  localparam logic [BYTE_W-1:0]  PAIR_MAX  = {DIGIT_MAX, DIGIT_MAX};

  adjOp_e op;
  logic   lowOver;
  logic   pairOver;

  always_comb begin
    op       = adjOp_e'(opSel);
    lowOver  = inAl[DIGIT_W-1:0] > DIGIT_MAX;
    pairOver = inAl > PAIR_MAX;

    stb.load     = inValid;
    stb.subtract = (op == OP_PACK_SUB) || (op == OP_UNP_SUB);
    stb.unpacked = (op == OP_UNP_ADD)  || (op == OP_UNP_SUB);
    stb.lowFix   = lowOver || inAf;
    stb.highFix  = !stb.unpacked && (pairOver || inCf);
  end

endmodule

// File: rtl/bcdadj_dp.sv
module bcdadj_dp
  import bcdadj_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter bit ZF_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  adjStrobe_t           stb,
  input  logic [2*DIGIT_W-1:0] inAl,
  input  logic [2*DIGIT_W-1:0] inAh,
  output logic [2*DIGIT_W-1:0] outAl,
  output logic [2*DIGIT_W-1:0] outAh,
  output logic                 outAf,
  output logic                 outCf,
  output logic                 outZf,
  output logic                 outValid
);

  localparam int BYTE_W = 2 * DIGIT_W;
  localparam logic [BYTE_W-1:0] LOW_STEP  = BYTE_W'((1 << DIGIT_W) - 10);
  localparam logic [BYTE_W-1:0] HIGH_STEP = LOW_STEP << DIGIT_W;

  logic [BYTE_W-1:0] stepTotal;
  logic [BYTE_W-1:0] alSum;
  logic [BYTE_W-1:0] nextAl;
  logic [BYTE_W-1:0] nextAh;
  logic              nextCf;

  always_comb begin
    stepTotal = (stb.lowFix  ? LOW_STEP  : '0)
              + (stb.highFix ? HIGH_STEP : '0);
    alSum     = stb.subtract ? (inAl - stepTotal) : (inAl + stepTotal);
    nextAl    = stb.unpacked ? {{DIGIT_W{1'b0}}, alSum[DIGIT_W-1:0]} : alSum;
    if (stb.unpacked && stb.lowFix)
      nextAh = stb.subtract ? (inAh - 1'b1) : (inAh + 1'b1);
    else
      nextAh = inAh;
    nextCf    = stb.unpacked ? stb.lowFix : stb.highFix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAl    <= '0;
      outAh    <= '0;
      outAf    <= 1'b0;
      outCf    <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.load;
      if (stb.load) begin
        outAl <= nextAl;
        outAh <= nextAh;
        outAf <= stb.lowFix;
        outCf <= nextCf;
      end
    end
  end

  generate
    if (ZF_EN) begin : g_zf
      logic zfQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         zfQ <= 1'b0;
        else if (stb.load) zfQ <= (nextAl == '0);
      end
      assign outZf = zfQ;

      AST_ZF_MATCH: assert property (@(posedge clk) disable iff (!rstN)
        outValid |-> (outZf == (outAl == '0)));  // R8
    end else begin : g_nozf
      assign outZf = 1'b0;
    end
  endgenerate

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> outValid);  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> (!outValid && $stable(outAl) && $stable(outAh)
                   && $stable(outAf) && $stable(outCf)));  // R9
  AST_UNPACKED_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.unpacked) |=> (outAl[BYTE_W-1:DIGIT_W] == '0));  // R5
  AST_UNPACKED_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.unpacked) |=> (outAf == outCf));  // R6
  AST_PACKED_AH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !stb.unpacked) |=> (outAh == $past(inAh)));  // R7

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcdadj_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter bit ZF_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [1:0]           opSel,
  input  logic [2*DIGIT_W-1:0] inAl,
  input  logic [2*DIGIT_W-1:0] inAh,
  input  logic                 inAf,
  input  logic                 inCf,
  output logic [2*DIGIT_W-1:0] outAl,
  output logic [2*DIGIT_W-1:0] outAh,
  output logic                 outAf,
  output logic                 outCf,
  output logic                 outZf,
  output logic                 outValid
);

  adjStrobe_t stb;

  bcdadj_ctrl #(.DIGIT_W(DIGIT_W)) ctrl_i (
    .inValid (inValid),
    .opSel   (opSel),
    .inAl    (inAl),
    .inAf    (inAf),
    .inCf    (inCf),
    .stb     (stb)
  );

  bcdadj_dp #(.DIGIT_W(DIGIT_W), .ZF_EN(ZF_EN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inAl     (inAl),
    .inAh     (inAh),
    .outAl    (outAl),
    .outAh    (outAh),
    .outAf    (outAf),
    .outCf    (outCf),
    .outZf    (outZf),
    .outValid (outValid)
  );

endmodule

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [1:0] opSel;
  logic [7:0] inAl, inAh;
  logic       inAf, inCf;
  logic [7:0] outAl, outAh;
  logic       outAf, outCf, outZf, outValid;

  always #5 clk = ~clk;

  bcd_adjust_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .inAl(inAl), .inAh(inAh), .inAf(inAf), .inCf(inCf),
    .outAl(outAl), .outAh(outAh), .outAf(outAf), .outCf(outCf),
    .outZf(outZf), .outValid(outValid)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // {op, al, ah, af, cf, expAl, expAh, expAf, expCf, expZf}
  localparam int NVEC = 18;
  localparam logic [38:0] VEC [NVEC] = '{
    {2'd0, 8'h0F, 8'h00, 1'b0, 1'b0, 8'h15, 8'h00, 1'b1, 1'b0, 1'b0}, // R3 example
    {2'd0, 8'h9A, 8'h33, 1'b0, 1'b0, 8'h00, 8'h33, 1'b1, 1'b1, 1'b1}, // R3 both, wrap
    {2'd0, 8'h45, 8'h7E, 1'b0, 1'b0, 8'h45, 8'h7E, 1'b0, 1'b0, 1'b0}, // R3 none
    {2'd0, 8'h12, 8'h00, 1'b1, 1'b1, 8'h78, 8'h00, 1'b1, 1'b1, 1'b0}, // R2 AF-only, CF-only
    {2'd1, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h99, 8'h00, 1'b1, 1'b1, 1'b0}, // R4 example
    {2'd1, 8'h34, 8'hA5, 1'b0, 1'b0, 8'h34, 8'hA5, 1'b0, 1'b0, 1'b0}, // R4 none
    {2'd1, 8'h0B, 8'h5C, 1'b0, 1'b0, 8'h05, 8'h5C, 1'b1, 1'b0, 1'b0}, // R4 low only
    {2'd1, 8'h66, 8'h00, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 flags in
    {2'd2, 8'h0F, 8'h00, 1'b0, 1'b0, 8'h05, 8'h01, 1'b1, 1'b1, 1'b0}, // R5 example
    {2'd2, 8'h08, 8'h03, 1'b0, 1'b0, 8'h08, 8'h03, 1'b0, 1'b0, 1'b0}, // R5 none
    {2'd2, 8'h3A, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1}, // R5 AH wrap
    {2'd2, 8'h72, 8'h10, 1'b1, 1'b0, 8'h08, 8'h11, 1'b1, 1'b1, 1'b0}, // R5 AF-only
    {2'd3, 8'hFF, 8'h02, 1'b0, 1'b0, 8'h09, 8'h01, 1'b1, 1'b1, 1'b0}, // R6 example
    {2'd3, 8'h25, 8'h04, 1'b0, 1'b1, 8'h05, 8'h04, 1'b0, 1'b0, 1'b0}, // R6 CF cleared
    {2'd3, 8'h03, 8'h00, 1'b1, 1'b0, 8'h0D, 8'hFF, 1'b1, 1'b1, 1'b0}, // R6 AH wrap
    {2'd3, 8'h06, 8'h09, 1'b1, 1'b0, 8'h00, 8'h08, 1'b1, 1'b1, 1'b1}, // R6 zero
    {2'd0, 8'h99, 8'h00, 1'b0, 1'b0, 8'h99, 8'h00, 1'b0, 1'b0, 1'b0}, // R3 thresholds
    {2'd0, 8'hA0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1}  // R3 high only
  };

  function automatic string opTag(input logic [1:0] op);
    case (op)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the falling edge after the loading rise.
  task automatic drive(input logic [1:0] op, input logic [7:0] al, input logic [7:0] ah,
                       input logic af, input logic cf);
    @(negedge clk);
    opSel = op; inAl = al; inAh = ah; inAf = af; inCf = cf; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b1; opSel = 2'd2; inAl = 8'h3F; inAh = 8'h12;
    inAf = 1'b1; inCf = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero despite an active request
    check("R1", "reset outputs", {outAl, outAh, outAf, outCf, outZf, outValid}, '0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "idle valid", {31'd0, outValid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [38:0] v;
      v = VEC[i];
      drive(v[38:37], v[36:29], v[28:21], v[20], v[19]);
      check("R9", "valid after request", {31'd0, outValid}, 32'd1);
      check(opTag(v[38:37]), "AL", {24'd0, outAl}, {24'd0, v[18:11]});
      check(v[38] ? opTag(v[38:37]) : "R7", "AH", {24'd0, outAh}, {24'd0, v[10:3]});
      check("R2", "AF", {31'd0, outAf}, {31'd0, v[2]});
      check(opTag(v[38:37]), "CF", {31'd0, outCf}, {31'd0, v[1]});
      check("R8", "ZF", {31'd0, outZf}, {31'd0, v[0]});
    end

    // R9: idle cycles with changed inputs leave the last result in place
    @(negedge clk);
    opSel = 2'd0; inAl = 8'hFF; inAh = 8'h55; inAf = 1'b1; inCf = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", "valid drops", {31'd0, outValid}, 32'd0);
    check("R9", "hold AL/AH", {16'd0, outAl, outAh}, {16'd0, 8'h00, 8'h00});
    check("R9", "hold flags", {29'd0, outAf, outCf, outZf}, {29'd0, 3'b011});

    // R9: back-to-back requests, each result one cycle later
    @(negedge clk);
    opSel = 2'd2; inAl = 8'h0F; inAh = 8'h00; inAf = 1'b0; inCf = 1'b0; inValid = 1'b1;
    @(negedge clk);
    check("R5", "back-to-back first", {16'd0, outAh, outAl}, {16'd0, 16'h0105});
    opSel = 2'd1; inAl = 8'hFF;
    @(negedge clk);
    inValid = 1'b0;
    check("R4", "back-to-back second", {23'd0, outAl, outCf}, {23'd0, 8'h99, 1'b1});
    check("R9", "valid held high", {31'd0, outValid}, 32'd1);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule